// File: doc/BRIEF.md
# Two-wire bus status flag logic

This block keeps the read-only status flags of a two-wire serial controller. A transfer engine reports events to it as single-cycle pulses: a byte arriving in the receive holding register, the transmit holding byte moving into the shifter, the shifter asking for a byte, a STOP sent by the master, a START or STOP seen as a slave, and a missing acknowledge. The bus side reports its own accesses as strobes: a status read, a receive holding read, a transmit holding write, and a master enable.

Every flag is a register that is set by its events and cleared by its strobes. When a set and a clear reach the same flag in one cycle, the set wins. The flags are packed into a 32-bit status word. When the shifter asks for a byte while in master mode and the holding register is empty, the block raises a one-cycle request that tells the engine to put a STOP on the bus. Every flag changes on the clock edge that samples its cause and is visible in the following cycle.

Top module: `twi_status_flags`

## Requirements
- R1: The status word puts transfer-complete at bit 0, receive-ready at bit 1, transmit-ready at bit 2, overrun at bit 6, underrun at bit 7 and not-acknowledged at bit 8. Every other bit reads 0.
- R2: A synchronous reset (rst high) clears every flag and the STOP request to 0.
- R3: A master enable pulse sets both transfer-complete and transmit-ready.
- R4: A received byte sets receive-ready. A receive holding read clears it.
- R5: A received byte that arrives while receive-ready is already 1 sets overrun.
- R6: A transmit holding write clears transmit-ready. A holding-to-shifter move sets it again.
- R7: A shifter request while transmit-ready is 1 sets underrun. In master mode it also raises stop_req for exactly the next cycle. In slave mode stop_req stays 0.
- R8: A status read clears overrun and underrun only if transfer-complete is 1 in that cycle. Otherwise they keep their value.
- R9: A detected NACK sets transmit-ready, transfer-complete and not-acknowledged in the same cycle. Any status read clears not-acknowledged.
- R10: In master mode, a transmit holding write clears transfer-complete. A sent STOP sets transfer-complete, but only while transmit-ready is 1.
- R11: In slave mode, a received START clears transfer-complete and a received STOP sets it.
- R12: When a set event and a clear strobe reach the same flag in one cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = master, 0 = slave (level) |
| en_master | input | 1 | Master enable pulse |
| ev_rx_byte | input | 1 | A byte was placed in the receive holding register |
| ev_hold_to_shift | input | 1 | The transmit holding byte moved into the shifter |
| ev_shift_req | input | 1 | The shifter asks for its next byte |
| ev_stop_sent | input | 1 | The master has sent STOP |
| ev_slv_start | input | 1 | START seen in slave mode |
| ev_slv_stop | input | 1 | STOP seen in slave mode |
| ev_nack | input | 1 | Missing acknowledge detected |
| rd_status | input | 1 | Status word read strobe |
| rd_rxhold | input | 1 | Receive holding read strobe |
| wr_txhold | input | 1 | Transmit holding write strobe |
| status_word | output | 32 | Packed flags |
| stop_req | output | 1 | One-cycle request to emit STOP |

## Verification
The assertions assume that every event and strobe input is a known value and is sampled at the rising edge. They also assume that master_mode is stable around the edge that samples an event. They make no assumption about which pulses share a cycle, because set-over-clear priority defines every combination. The stimulus changes inputs only on the falling edge. It drives master_mode as a level that changes rarely, and pulses the other inputs at random, often several together, so that set and clear collisions occur often.

// File: rtl/twi_status_pkg.sv
package twi_status_pkg;
    localparam int WORD_W    = 32;
    localparam int BIT_COMP  = 0;
    localparam int BIT_RXRDY = 1;
    localparam int BIT_TXRDY = 2;
    localparam int BIT_OVRE  = 6;
    localparam int BIT_UNRE  = 7;
    localparam int BIT_NACK  = 8;

    typedef struct packed {
        logic comp;
        logic rxrdy;
        logic txrdy;
        logic ovre;
        logic unre;
        logic nack;
    } flags_t;

    function automatic logic [WORD_W-1:0] pack_flags(input flags_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_COMP]  = f.comp;
        w[BIT_RXRDY] = f.rxrdy;
        w[BIT_TXRDY] = f.txrdy;
        w[BIT_OVRE]  = f.ovre;
        w[BIT_UNRE]  = f.unre;
        w[BIT_NACK]  = f.nack;
        return w;
    endfunction
endpackage

// File: rtl/twi_flag_cell.sv
module twi_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);
endmodule

// File: rtl/twi_rx_flags.sv
module twi_rx_flags (
    input  logic clk,
    input  logic rst,
    input  logic ev_rx_byte,
    input  logic rd_rxhold,
    input  logic rd_status,
    input  logic comp_i,
    output logic rxrdy_o,
    output logic ovre_o
);
    logic ovre_set, err_clr;

    assign ovre_set = ev_rx_byte & rxrdy_o;
    assign err_clr  = rd_status & comp_i;

    twi_flag_cell u_rxrdy (.clk(clk), .rst(rst), .set_i(ev_rx_byte),
                           .clr_i(rd_rxhold), .q_o(rxrdy_o));
    twi_flag_cell u_ovre  (.clk(clk), .rst(rst), .set_i(ovre_set),
                           .clr_i(err_clr), .q_o(ovre_o));

    p_rx_set_r4: assert property (@(posedge clk) disable iff (rst)
        ev_rx_byte |=> rxrdy_o);
    p_rx_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_rxhold && !ev_rx_byte) |=> !rxrdy_o);
    p_overrun_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_rx_byte && rxrdy_o) |=> ovre_o);
    p_ovre_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ovre_o && !comp_i) |=> ovre_o);
endmodule

// File: rtl/twi_tx_flags.sv
module twi_tx_flags (
    input  logic clk,
    input  logic rst,
    input  logic master_mode,
    input  logic en_master,
    input  logic ev_hold_to_shift,
    input  logic ev_shift_req,
    input  logic ev_nack,
    input  logic wr_txhold,
    input  logic rd_status,
    input  logic comp_i,
    output logic txrdy_o,
    output logic unre_o,
    output logic stop_req_o
);
    logic txrdy_set, unre_set, err_clr;

    assign txrdy_set = en_master | ev_hold_to_shift | ev_nack;
    assign unre_set  = ev_shift_req & txrdy_o;
    assign err_clr   = rd_status & comp_i;

    twi_flag_cell u_txrdy (.clk(clk), .rst(rst), .set_i(txrdy_set),
                           .clr_i(wr_txhold), .q_o(txrdy_o));
    twi_flag_cell u_unre  (.clk(clk), .rst(rst), .set_i(unre_set),
                           .clr_i(err_clr), .q_o(unre_o));

    always_ff @(posedge clk) begin
        if (rst) stop_req_o <= 1'b0;
        else     stop_req_o <= unre_set & master_mode;
    end

    p_txrdy_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_txhold && !en_master && !ev_hold_to_shift && !ev_nack) |=> !txrdy_o);
    p_underrun_r7: assert property (@(posedge clk) disable iff (rst)
        (ev_shift_req && txrdy_o) |=> unre_o);
    p_stop_req_r7: assert property (@(posedge clk) disable iff (rst)
        (ev_shift_req && txrdy_o && master_mode) |=> stop_req_o);
    p_stop_slave_r7: assert property (@(posedge clk) disable iff (rst)
        !master_mode |=> !stop_req_o);
    p_unre_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (unre_o && !comp_i) |=> unre_o);
    p_nack_txrdy_r9: assert property (@(posedge clk) disable iff (rst)
        ev_nack |=> txrdy_o);
endmodule

// File: rtl/twi_comp_flags.sv
module twi_comp_flags (
    input  logic clk,
    input  logic rst,
    input  logic master_mode,
    input  logic en_master,
    input  logic ev_nack,
    input  logic ev_stop_sent,
    input  logic ev_slv_start,
    input  logic ev_slv_stop,
    input  logic wr_txhold,
    input  logic rd_status,
    input  logic txrdy_i,
    output logic comp_o,
    output logic nack_o
);
    logic comp_set, comp_clr;

    always_comb begin
        comp_set = en_master | ev_nack;
        comp_clr = 1'b0;
        if (master_mode) begin
            comp_set = comp_set | (ev_stop_sent & txrdy_i);
            comp_clr = wr_txhold;
        end else begin
            comp_set = comp_set | ev_slv_stop;
            comp_clr = ev_slv_start;
        end
    end

    twi_flag_cell u_comp (.clk(clk), .rst(rst), .set_i(comp_set),
                          .clr_i(comp_clr), .q_o(comp_o));
    twi_flag_cell u_nack (.clk(clk), .rst(rst), .set_i(ev_nack),
                          .clr_i(rd_status), .q_o(nack_o));

    p_enable_r3: assert property (@(posedge clk) disable iff (rst)
        en_master |=> comp_o);
    p_nack_all_r9: assert property (@(posedge clk) disable iff (rst)
        ev_nack |=> (comp_o && nack_o));
    p_nack_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !ev_nack) |=> !nack_o);
    p_master_stop_r10: assert property (@(posedge clk) disable iff (rst)
        (master_mode && ev_stop_sent && txrdy_i) |=> comp_o);
    p_slave_stop_r11: assert property (@(posedge clk) disable iff (rst)
        (!master_mode && ev_slv_stop) |=> comp_o);
    p_slave_start_r11: assert property (@(posedge clk) disable iff (rst)
        (!master_mode && ev_slv_start && !ev_slv_stop && !ev_nack && !en_master)
        |=> !comp_o);
endmodule

// File: rtl/twi_status_flags.sv
module twi_status_flags
    import twi_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              en_master,
    input  logic              ev_rx_byte,
    input  logic              ev_hold_to_shift,
    input  logic              ev_shift_req,
    input  logic              ev_stop_sent,
    input  logic              ev_slv_start,
    input  logic              ev_slv_stop,
    input  logic              ev_nack,
    input  logic              rd_status,
    input  logic              rd_rxhold,
    input  logic              wr_txhold,
    output logic [WORD_W-1:0] status_word,
    output logic              stop_req
);
    flags_t fl;

    twi_rx_flags u_rx (
        .clk(clk), .rst(rst), .ev_rx_byte(ev_rx_byte), .rd_rxhold(rd_rxhold),
        .rd_status(rd_status), .comp_i(fl.comp),
        .rxrdy_o(fl.rxrdy), .ovre_o(fl.ovre));

    twi_tx_flags u_tx (
        .clk(clk), .rst(rst), .master_mode(master_mode), .en_master(en_master),
        .ev_hold_to_shift(ev_hold_to_shift), .ev_shift_req(ev_shift_req),
        .ev_nack(ev_nack), .wr_txhold(wr_txhold), .rd_status(rd_status),
        .comp_i(fl.comp), .txrdy_o(fl.txrdy), .unre_o(fl.unre),
        .stop_req_o(stop_req));

    twi_comp_flags u_comp (
        .clk(clk), .rst(rst), .master_mode(master_mode), .en_master(en_master),
        .ev_nack(ev_nack), .ev_stop_sent(ev_stop_sent),
        .ev_slv_start(ev_slv_start), .ev_slv_stop(ev_slv_stop),
        .wr_txhold(wr_txhold), .rd_status(rd_status), .txrdy_i(fl.txrdy),
        .comp_o(fl.comp), .nack_o(fl.nack));

    assign status_word = pack_flags(fl);

    p_reset_r2: assert property (@(posedge clk) rst |=> (status_word == '0 && !stop_req));
endmodule

// File: tb/tb_twi_status_flags.sv
module tb_twi_status_flags;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mm = 1'b0, en = 1'b0, rxb = 1'b0, h2s = 1'b0, sreq = 1'b0, ssent = 1'b0;
    logic sst = 1'b0, ssp = 1'b0, nk = 1'b0, rds = 1'b0, rdr = 1'b0, wrt = 1'b0;
    logic [31:0] word;
    logic        sreq_o;

    int n_chk = 0, n_bad = 0;
    bit e_comp, e_rxrdy, e_txrdy, e_ovre, e_unre, e_nack, e_stop;

    always #5 clk = ~clk;

    twi_status_flags dut (
        .clk(clk), .rst(rst), .master_mode(mm), .en_master(en), .ev_rx_byte(rxb),
        .ev_hold_to_shift(h2s), .ev_shift_req(sreq), .ev_stop_sent(ssent),
        .ev_slv_start(sst), .ev_slv_stop(ssp), .ev_nack(nk), .rd_status(rds),
        .rd_rxhold(rdr), .wr_txhold(wrt), .status_word(word), .stop_req(sreq_o));

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        w[0] = e_comp; w[1] = e_rxrdy; w[2] = e_txrdy;
        w[6] = e_ovre; w[7] = e_unre;  w[8] = e_nack;
        return w;
    endfunction

    // next state of the expected flags, from the requirements
    task automatic model_step();
        bit c, r, t, o, u, n, s, cs, cc;
        if (rst) begin
            c = 0; r = 0; t = 0; o = 0; u = 0; n = 0; s = 0;
        end else begin
            r = rxb ? 1'b1 : (rdr ? 1'b0 : e_rxrdy);
            o = (rxb && e_rxrdy) ? 1'b1 : ((rds && e_comp) ? 1'b0 : e_ovre);
            t = (en || h2s || nk) ? 1'b1 : (wrt ? 1'b0 : e_txrdy);
            u = (sreq && e_txrdy) ? 1'b1 : ((rds && e_comp) ? 1'b0 : e_unre);
            s = sreq && e_txrdy && mm;
            n = nk ? 1'b1 : (rds ? 1'b0 : e_nack);
            cs = en || nk || (mm ? (ssent && e_txrdy) : ssp);
            cc = mm ? wrt : sst;
            c = cs ? 1'b1 : (cc ? 1'b0 : e_comp);
        end
        e_comp = c; e_rxrdy = r; e_txrdy = t; e_ovre = o; e_unre = u;
        e_nack = n; e_stop = s;
    endtask

    task automatic check(input string tag);
        n_chk++;
        if (word !== exp_word() || sreq_o !== e_stop) begin
            n_bad++;
            $display("FAIL %s: word=%h stop=%b expected word=%h stop=%b",
                     tag, word, sreq_o, exp_word(), e_stop);
        end
    endtask

    task automatic clear_in();
        en = 0; rxb = 0; h2s = 0; sreq = 0; ssent = 0;
        sst = 0; ssp = 0; nk = 0; rds = 0; rdr = 0; wrt = 0;
    endtask

    // inputs already set after a falling edge; run one edge and check
    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        #1;
        check(tag);
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: expired, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        rst = 1;
        tick("R2 reset clears");
        tick("R2 reset clears again");
        rst = 0;
        en = 1;                    tick("R3 enable sets comp and txrdy");
        rxb = 1;                   tick("R4 byte sets rxrdy");
        rxb = 1;                   tick("R5 byte while rxrdy sets overrun");
        rdr = 1;                   tick("R4 holding read clears rxrdy");
        mm = 1; wrt = 1;           tick("R6 R10 write clears txrdy and comp");
        rds = 1;                   tick("R8 status read with comp 0 keeps overrun");
        ssent = 1;                 tick("R10 stop with holding full no comp");
        h2s = 1;                   tick("R6 move to shifter sets txrdy");
        sreq = 1;                  tick("R7 underrun and stop request");
        ssent = 1;                 tick("R10 stop sent sets comp, R7 stop_req one cycle");
        rds = 1;                   tick("R8 status read with comp 1 clears errors");
        wrt = 1; nk = 1;           tick("R9 R12 nack beats write");
        rds = 1;                   tick("R9 status read clears nack");
        mm = 0; sst = 1;           tick("R11 slave start clears comp");
        sreq = 1; en = 1;          tick("R7 slave underrun no stop request");
        sst = 1;                   tick("R11 slave start clears comp");
        ssp = 1;                   tick("R11 slave stop sets comp");
        rxb = 1; rdr = 1;          tick("R12 byte beats holding read");
        sst = 1; ssp = 1;          tick("R12 slave stop beats start");
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 99) < 3) mm = ~mm;
            en    = ($urandom_range(0, 99) < 4);
            rxb   = ($urandom_range(0, 99) < 25);
            h2s   = ($urandom_range(0, 99) < 20);
            sreq  = ($urandom_range(0, 99) < 20);
            ssent = ($urandom_range(0, 99) < 15);
            sst   = ($urandom_range(0, 99) < 15);
            ssp   = ($urandom_range(0, 99) < 15);
            nk    = ($urandom_range(0, 99) < 6);
            rds   = ($urandom_range(0, 99) < 25);
            rdr   = ($urandom_range(0, 99) < 25);
            wrt   = ($urandom_range(0, 99) < 20);
            tick("R1 random mix layout");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule